// File: doc/BRIEF.md
# MSI-X capability register slice

This block holds the configuration-space registers of an MSI-X capability: an identifier byte, a link byte to the next capability, a 16-bit message control word, and two read-only dwords. One dword locates the vector table and the other locates the pending-bit array, both inside one memory BAR. A configuration access reaches the block with an offset relative to the capability base, a size code for 1, 2 or 4 bytes, and byte lanes that line up with that offset. Lane 0 carries the byte at the offset and lane i carries the byte at offset+i.

Software can change only two bits: the enable bit and the function-mask bit in the upper byte of message control. The block drives both bits as registered outputs for the vector logic. When a write leaves the function newly able to signal, the block raises a single-cycle rescan strobe. The vector-table block uses that strobe to re-examine its pending bits.

Top module: `msix_cap_regs`

## Requirements
- R1: After reset, `msix_en`, `msix_fmask` and `rescan` are all 0.
- R2: Offset 0 reads the parameter `CAP_ID` (default 0x11) and offset 1 reads `NEXT_PTR`. Writes to either byte have no effect.
- R3: Message control sits at offsets 2 and 3, little-endian. Bits 9:0 read `VEC_COUNT-1`, bits 13:10 read 0, bit 14 is function mask and bit 15 is enable. Writes leave bits 13:0 unchanged.
- R4: A write of any size whose lanes cover offset 3 loads bit 6 of that lane's byte into function mask and bit 7 into enable. A write that does not cover offset 3 leaves both bits unchanged.
- R5: The dword at offset 4 reads `BAR_IDX`, meaning table offset 0 ORed with the BAR index. The dword at offset 8 reads 0x800 ORed with `BAR_IDX`. Both ignore writes, and `BAR_IDX` must lie in 0 to 5.
- R6: A read is requested with `cfg_rd`. Size code 0 returns 1 byte, code 1 returns 2 bytes, and codes 2 and 3 return 4 bytes. The data is little-endian from the given offset, with unused upper lanes and offsets 12 and above reading 0. `rd_valid` and `rd_data` appear on the cycle after the request, for one cycle.
- R7: `rescan` is high for exactly one cycle, the cycle after a write that either sets enable from 0 to 1 or clears function mask from 1 to 0. A write that makes both changes gives a single pulse, and any other write gives none.
- R8: Enable and function mask change only in the cycle after a write, and hold their values otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_rd | input | 1 | Configuration read strobe |
| cfg_off | input | OFF_W | Byte offset from capability base |
| cfg_size | input | 2 | 0: 1 byte, 1: 2 bytes, 2/3: 4 bytes |
| cfg_wdata | input | 32 | Write data, lane i is byte at offset+i |
| rd_data | output | 32 | Read data, lane i is byte at offset+i |
| rd_valid | output | 1 | Read data valid |
| msix_en | output | 1 | MSI-X enable |
| msix_fmask | output | 1 | Function mask |
| rescan | output | 1 | Pending-vector rescan strobe |

## Verification
Every result is due one clock after the edge that samples its request. Read data and `rd_valid` follow a `cfg_rd` by one cycle. The enable and mask outputs, and the rescan strobe, follow a `cfg_wr` by one cycle, and the strobe must be low again one cycle later. The bench drives requests on falling edges and queues each expected read word as it issues it. A monitor pops that word on the falling edge after `rd_valid` rises. Write effects and the strobe are sampled on the first falling edge after the write edge, and the strobe's drop is sampled on the next falling edge.

// File: rtl/msix_cap_pkg.sv
package msix_cap_pkg;
  localparam int CAP_BYTES   = 12;
  localparam int LOC_ID      = 0;
  localparam int LOC_NEXT    = 1;
  localparam int LOC_CTRL_HI = 3;
  localparam int TBL_BASE    = 32'h0000_0000;
  localparam int PBA_BASE    = 32'h0000_0800;

  typedef enum logic [1:0] {
    SZ_B1 = 2'd0,
    SZ_B2 = 2'd1,
    SZ_B4 = 2'd2,
    SZ_B4X = 2'd3
  } acc_size_e;

  function automatic int size_to_bytes(input logic [1:0] code);
    case (acc_size_e'(code))
      SZ_B1:   return 1;
      SZ_B2:   return 2;
      default: return 4;
    endcase
  endfunction
endpackage

// File: rtl/msix_cap_lane_dec.sv
module msix_cap_lane_dec
  import msix_cap_pkg::*;
#(
  parameter int OFF_W = 4,
  parameter int LANES = 4
) (
  input  logic [OFF_W-1:0]     off,
  input  logic [1:0]           size,
  input  logic [8*LANES-1:0]   wdata,
  output logic                 hi_hit,
  output logic [7:0]           hi_byte
);
  localparam int AW = OFF_W + 1;

  logic [LANES-1:0]         lane_act;
  logic [LANES-1:0][AW-1:0] lane_loc;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign lane_act[i] = size_to_bytes(size) > i;
    assign lane_loc[i] = AW'({1'b0, off}) + AW'(i);
  end

  // Lanes are applied in increasing address order; a later lane wins.
  always_comb begin
    hi_hit  = 1'b0;
    hi_byte = 8'h00;
    for (int i = 0; i < LANES; i++) begin
      if (lane_act[i] && lane_loc[i] == AW'(LOC_CTRL_HI)) begin
        hi_hit  = 1'b1;
        hi_byte = wdata[8*i +: 8];
      end
    end
  end
endmodule

// File: rtl/msix_cap_ctrl.sv
module msix_cap_ctrl (
  input  logic       clk,
  input  logic       rst,
  input  logic       wr,
  input  logic       hi_hit,
  input  logic [7:0] hi_byte,
  output logic       en,
  output logic       fmask,
  output logic       rescan
);
  logic en_nx, fm_nx;

  always_comb begin
    en_nx = en;
    fm_nx = fmask;
    if (wr && hi_hit) begin
      en_nx = hi_byte[7];
      fm_nx = hi_byte[6];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en     <= 1'b0;
      fmask  <= 1'b0;
      rescan <= 1'b0;
    end else begin
      en     <= en_nx;
      fmask  <= fm_nx;
      rescan <= (!en && en_nx) || (fmask && !fm_nx);
    end
  end
endmodule

// File: rtl/msix_cap_rdmux.sv
module msix_cap_rdmux
  import msix_cap_pkg::*;
#(
  parameter int         OFF_W     = 4,
  parameter int         LANES     = 4,
  parameter int         VEC_COUNT = 8,
  parameter logic [7:0] CAP_ID    = 8'h11,
  parameter logic [7:0] NEXT_PTR  = 8'h00,
  parameter int         BAR_IDX   = 0
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 rd,
  input  logic [OFF_W-1:0]     off,
  input  logic [1:0]           size,
  input  logic                 en,
  input  logic                 fmask,
  output logic [8*LANES-1:0]   rdata,
  output logic                 rvalid
);
  localparam int          AW    = OFF_W + 1;
  localparam logic [9:0]  TSIZE = 10'(VEC_COUNT - 1);
  localparam logic [31:0] TBL_W = 32'(TBL_BASE) | 32'(BAR_IDX);
  localparam logic [31:0] PBA_W = 32'(PBA_BASE) | 32'(BAR_IDX);

  logic [8*CAP_BYTES-1:0] image;
  logic [8*LANES-1:0]     rd_nx;

  assign image = {PBA_W, TBL_W, en, fmask, 4'b0000, TSIZE, NEXT_PTR, CAP_ID};

  always_comb begin
    rd_nx = '0;
    for (int i = 0; i < LANES; i++) begin
      logic [AW-1:0] loc;
      loc = AW'({1'b0, off}) + AW'(i);
      if (size_to_bytes(size) > i && int'(loc) < CAP_BYTES)
        rd_nx[8*i +: 8] = image[8*int'(loc) +: 8];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata  <= '0;
      rvalid <= 1'b0;
    end else begin
      rvalid <= rd;
      if (rd) rdata <= rd_nx;
    end
  end
endmodule

// File: rtl/msix_cap_regs.sv
module msix_cap_regs
  import msix_cap_pkg::*;
#(
  parameter int         OFF_W     = 4,
  parameter int         VEC_COUNT = 8,
  parameter logic [7:0] CAP_ID    = 8'h11,
  parameter logic [7:0] NEXT_PTR  = 8'h00,
  parameter int         BAR_IDX   = 0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_wr,
  input  logic             cfg_rd,
  input  logic [OFF_W-1:0] cfg_off,
  input  logic [1:0]       cfg_size,
  input  logic [31:0]      cfg_wdata,
  output logic [31:0]      rd_data,
  output logic             rd_valid,
  output logic             msix_en,
  output logic             msix_fmask,
  output logic             rescan
);
  localparam int LANES = 4;

  if (BAR_IDX < 0 || BAR_IDX > 5) begin : g_bad_bar
    $error("BAR_IDX must be between 0 and 5");
  end
  if (VEC_COUNT < 1 || VEC_COUNT > 1024) begin : g_bad_cnt
    $error("VEC_COUNT must be between 1 and 1024");
  end

  logic       hi_hit;
  logic [7:0] hi_byte;

  msix_cap_lane_dec #(.OFF_W(OFF_W), .LANES(LANES)) u_dec (
    .off     (cfg_off),
    .size    (cfg_size),
    .wdata   (cfg_wdata),
    .hi_hit  (hi_hit),
    .hi_byte (hi_byte)
  );

  msix_cap_ctrl u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .wr      (cfg_wr),
    .hi_hit  (hi_hit),
    .hi_byte (hi_byte),
    .en      (msix_en),
    .fmask   (msix_fmask),
    .rescan  (rescan)
  );

  msix_cap_rdmux #(
    .OFF_W(OFF_W), .LANES(LANES), .VEC_COUNT(VEC_COUNT),
    .CAP_ID(CAP_ID), .NEXT_PTR(NEXT_PTR), .BAR_IDX(BAR_IDX)
  ) u_rd (
    .clk    (clk),
    .rst    (rst),
    .rd     (cfg_rd),
    .off    (cfg_off),
    .size   (cfg_size),
    .en     (msix_en),
    .fmask  (msix_fmask),
    .rdata  (rd_data),
    .rvalid (rd_valid)
  );
endmodule

// File: rtl/msix_cap_checker.sv
module msix_cap_checker (
  input logic clk,
  input logic rst,
  input logic cfg_wr,
  input logic cfg_rd,
  input logic rd_valid,
  input logic msix_en,
  input logic msix_fmask,
  input logic rescan
);
  // R1: outputs are cleared by reset
  a_r1_reset_clear: assert property (@(posedge clk)
    $past(rst) |-> (!msix_en && !msix_fmask && !rescan));

  // R7: a strobe only follows a write that opened the function
  a_r7_rescan_cause: assert property (@(posedge clk) disable iff (rst)
    rescan |-> ($past(cfg_wr) &&
               ((msix_en && !$past(msix_en)) || (!msix_fmask && $past(msix_fmask)))));

  // R8: without a write the control bits hold
  a_r8_hold_no_write: assert property (@(posedge clk) disable iff (rst)
    !cfg_wr |=> ($stable(msix_en) && $stable(msix_fmask)));

  // R6: every read answers on the next cycle
  a_r6_read_answers: assert property (@(posedge clk) disable iff (rst)
    cfg_rd |=> rd_valid);

  // R6: no answer without a request
  a_r6_valid_requested: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> $past(cfg_rd));
endmodule

bind msix_cap_regs msix_cap_checker u_chk (
  .clk        (clk),
  .rst        (rst),
  .cfg_wr     (cfg_wr),
  .cfg_rd     (cfg_rd),
  .rd_valid   (rd_valid),
  .msix_en    (msix_en),
  .msix_fmask (msix_fmask),
  .rescan     (rescan)
);

// File: tb/msix_cap_regs_bench.sv
module msix_cap_regs_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_wr = 1'b0;
  logic        cfg_rd = 1'b0;
  logic [3:0]  cfg_off = '0;
  logic [1:0]  cfg_size = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] rd_data;
  logic        rd_valid;
  logic        msix_en;
  logic        msix_fmask;
  logic        rescan;

  int checks = 0;
  int errors = 0;
  logic [31:0] q_exp[$];
  string       q_tag[$];

  always #5 clk = ~clk;

  msix_cap_regs #(
    .OFF_W(4), .VEC_COUNT(64), .CAP_ID(8'h11), .NEXT_PTR(8'h70), .BAR_IDX(2)
  ) u_msix_cap_regs (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_rd(cfg_rd),
    .cfg_off(cfg_off), .cfg_size(cfg_size), .cfg_wdata(cfg_wdata),
    .rd_data(rd_data), .rd_valid(rd_valid),
    .msix_en(msix_en), .msix_fmask(msix_fmask), .rescan(rescan)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Monitor: pops expected read words as the design answers.
  always @(negedge clk) begin
    if (!rst && rd_valid) begin
      if (q_exp.size() == 0) begin
        check(1'b0, "R6 unexpected rd_valid", 32'h1, 32'h0);
      end else begin
        logic [31:0] e;
        string t;
        e = q_exp.pop_front();
        t = q_tag.pop_front();
        check(rd_data === e, t, rd_data, e);
      end
    end
  end

  task automatic do_read(input logic [3:0] off, input logic [1:0] sz,
                         input logic [31:0] exp, input string tag);
    @(negedge clk);
    cfg_rd = 1'b1; cfg_off = off; cfg_size = sz;
    q_exp.push_back(exp);
    q_tag.push_back(tag);
    @(negedge clk);
    cfg_rd = 1'b0;
  endtask

  task automatic do_write(input logic [3:0] off, input logic [1:0] sz,
                          input logic [31:0] data, input bit exp_en,
                          input bit exp_fm, input bit exp_rs, input string tag);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_off = off; cfg_size = sz; cfg_wdata = data;
    @(negedge clk);
    cfg_wr = 1'b0;
    check(msix_en === exp_en, {tag, " enable"}, 32'(msix_en), 32'(exp_en));
    check(msix_fmask === exp_fm, {tag, " fmask"}, 32'(msix_fmask), 32'(exp_fm));
    check(rescan === exp_rs, "R7 rescan after write", 32'(rescan), 32'(exp_rs));
    @(negedge clk);
    check(rescan === 1'b0, "R7 rescan one cycle only", 32'(rescan), 32'h0);
  endtask

  initial begin
    #200000;
    check(1'b0, "watchdog expired", 32'h1, 32'h0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(msix_en === 1'b0, "R1 enable reset", 32'(msix_en), 32'h0);
    check(msix_fmask === 1'b0, "R1 fmask reset", 32'(msix_fmask), 32'h0);
    check(rescan === 1'b0, "R1 rescan reset", 32'(rescan), 32'h0);

    do_read(4'd0, 2'd2, 32'h003F_7011, "R2 R3 dword at 0");
    do_read(4'd0, 2'd0, 32'h0000_0011, "R2 id byte");
    do_read(4'd1, 2'd0, 32'h0000_0070, "R2 next byte");
    do_read(4'd2, 2'd1, 32'h0000_003F, "R3 control word");
    do_read(4'd1, 2'd1, 32'h0000_3F70, "R6 unaligned word");
    do_read(4'd4, 2'd2, 32'h0000_0002, "R5 table dword");
    do_read(4'd8, 2'd3, 32'h0000_0802, "R5 pending dword");
    do_read(4'd9, 2'd0, 32'h0000_0008, "R6 byte inside pending dword");
    do_read(4'd10, 2'd1, 32'h0000_0000, "R6 upper pending word");
    do_read(4'd12, 2'd2, 32'h0000_0000, "R6 past capability end");
    do_read(4'd11, 2'd2, 32'h0000_0000, "R6 straddling end");

    do_write(4'd0, 2'd2, 32'hFFFF_FFFF, 1, 1, 1, "R4 dword write sets both");
    do_read(4'd0, 2'd2, 32'hC03F_7011, "R3 R2 read-only bits kept");
    do_write(4'd2, 2'd1, 32'h0000_0000, 0, 0, 1, "R4 word write clears");
    do_write(4'd3, 2'd0, 32'h0000_0040, 0, 1, 0, "R4 mask only");
    do_read(4'd3, 2'd0, 32'h0000_0040, "R3 high byte");
    do_write(4'd3, 2'd0, 32'h0000_00C0, 1, 1, 1, "R7 enable rises");
    do_write(4'd3, 2'd0, 32'h0000_00C0, 1, 1, 0, "R7 no change no pulse");
    do_write(4'd4, 2'd2, 32'hFFFF_FFFF, 1, 1, 0, "R5 table write");
    do_read(4'd4, 2'd2, 32'h0000_0002, "R5 table ignores write");
    do_write(4'd8, 2'd2, 32'hFFFF_FFFF, 1, 1, 0, "R5 pending write");
    do_read(4'd8, 2'd2, 32'h0000_0802, "R5 pending ignores write");
    do_write(4'd0, 2'd0, 32'h0000_00FF, 1, 1, 0, "R2 id write");
    do_write(4'd2, 2'd0, 32'h0000_00FF, 1, 1, 0, "R3 low control write");
    do_read(4'd0, 2'd2, 32'hC03F_7011, "R2 R3 after ignored writes");
    do_write(4'd3, 2'd0, 32'h0000_0080, 1, 0, 1, "R7 mask falls");
    do_write(4'd3, 2'd0, 32'h0000_0040, 0, 1, 0, "R7 close no pulse");
    do_write(4'd3, 2'd0, 32'h0000_0080, 1, 0, 1, "R7 both edges single pulse");
    do_write(4'd1, 2'd2, 32'h0000_0000, 0, 0, 0, "R4 lane two hits offset 3");
    do_write(4'd0, 2'd0, 32'h0000_00C0, 0, 0, 0, "R4 offset 0 lane leaves bits");
    do_write(4'd2, 2'd0, 32'h0000_00C0, 0, 0, 0, "R8 offset 2 byte leaves bits");

    repeat (3) @(negedge clk);
    check(q_exp.size() == 0, "R6 reads all answered", 32'(q_exp.size()), 32'h0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule